// File: doc/BRIEF.md
# Instruction cycle phase controller

This block is the sequencing core of a small accumulator machine. It moves every instruction through a sequence of one-cycle phases, each named by a two-bit code. An instruction is fetched and decoded first. An operand read from data memory follows only when the instruction names a memory address instead of carrying its value. The instruction then executes.

An interrupt request is looked at only as an instruction finishes. When it is taken, an extra phase saves the address of the next instruction on a small last-in-first-out stack and redirects execution to a fixed service-routine entry. A return instruction pops the saved address, so the interrupted program continues where it stopped.

Both memories are synchronous: an address presented in one cycle yields its data in the next. The controller therefore presents the address of the next instruction one cycle ahead of the fetch phase that uses it.

Top module: `cycle_sequencer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the phase code is 00, the program counter and accumulator are zero, the interrupt enable output is 1 and the stack error flag is 0.
- R2: The phase code is 00 for fetch, 01 for operand read, 10 for execute and 11 for interrupt entry. Each phase lasts one cycle. An operand read is always followed by execute, and interrupt entry is always followed by fetch.
- R3: The instruction word carries the opcode in bits 15:12, a mode bit in bit 11 (0 = the value is in the word, 1 = the field is a data address) and an 11-bit field in bits 10:0. Opcodes: 0 no-op, 1 add, 2 load, 3 jump, 4 return, 5 enable interrupts; any other code acts as a no-op. In value mode, add and load use the zero-extended field, the sum wraps modulo 2^16, and fetch goes straight to execute with no data read.
- R4: In address mode, add, load and jump pass through the operand phase. In that phase the data read strobe is 1 and the data address equals the field. The word returned in the next cycle is the operand used in execute.
- R5: Fetch advances the program counter by one. Jump loads the field (value mode) or the low 11 bits of the data word read (address mode). The instruction address output always shows the address of the instruction that the next fetch phase will decode.
- R6: The interrupt request is sampled only at the end of execute. If interrupts are enabled, phase 11 follows and the enable drops to 0. Otherwise fetch follows.
- R7: Phase 11 pushes the program counter, which then holds the address of the next instruction, and loads the service address 0x7F0.
- R8: Return pops the most recently pushed address into the program counter and sets the interrupt enable. Enable-interrupts sets the enable without touching the stack.
- R9: A push onto a full stack (4 entries) or a return on an empty stack sets a sticky error flag and leaves the program counter unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 11 | Instruction address, one cycle ahead of fetch |
| imem_data | input | 16 | Instruction word for the address presented in the previous cycle |
| dmem_addr | output | 11 | Data read address |
| dmem_rd | output | 1 | Data read strobe, high in the operand phase |
| dmem_rdata | input | 16 | Data word for the address presented in the previous cycle |
| irq | input | 1 | Interrupt request, level sensitive |
| phase | output | 2 | Current phase code |
| pc | output | 11 | Program counter |
| acc | output | 16 | Accumulator |
| irq_en | output | 1 | Interrupt enable state |
| stack_err | output | 1 | Sticky stack overflow or underflow flag |

## Verification
On every cycle, properties check the phase order, the skipped operand phase in value mode, the data address presented after an address-mode fetch, the increment at fetch, the interrupt entry with its enable drop, the load of the service vector, the pop target, and the error on a full push together with its stickiness. Only the bench programs can show the accumulator arithmetic with wrap-around, jump targets taken from memory, nested entries that fill the stack and unwind in last-in-first-out order, and the resumption of the interrupted program with its accumulator intact.

// File: rtl/cycle_sequencer.sv
module cycle_sequencer #(
  parameter int AW = 11,
  parameter int DW = 16,
  parameter int STACK_DEPTH = 4,
  parameter logic [AW-1:0] ISR_ADDR = 'h7F0
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] imem_addr,
  input  logic [4+AW:0] imem_data,
  output logic [AW-1:0] dmem_addr,
  output logic          dmem_rd,
  input  logic [DW-1:0] dmem_rdata,
  input  logic          irq,
  output logic [1:0]    phase,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] acc,
  output logic          irq_en,
  output logic          stack_err
);
  localparam int OPW = 4;
  localparam int IW  = OPW + 1 + AW;
  localparam int SPW = $clog2(STACK_DEPTH + 1);
  localparam int SIW = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;

  localparam logic [OPW-1:0] OP_ADD  = 4'd1;
  localparam logic [OPW-1:0] OP_LOAD = 4'd2;
  localparam logic [OPW-1:0] OP_JUMP = 4'd3;
  localparam logic [OPW-1:0] OP_RET  = 4'd4;
  localparam logic [OPW-1:0] OP_ENI  = 4'd5;

  typedef enum logic [1:0] {
    PH_FETCH = 2'b00,
    PH_OPND  = 2'b01,
    PH_EXEC  = 2'b10,
    PH_INTR  = 2'b11
  } phase_t;

  phase_t          ph, ph_d;
  logic [AW-1:0]   pc_q, pc_d;
  logic [DW-1:0]   acc_q;
  logic [IW-1:0]   ir;
  logic            ie_q, err_q;
  logic [SPW-1:0]  sp;
  logic [AW-1:0]   stk [STACK_DEPTH];

  wire [OPW-1:0] f_op   = imem_data[IW-1 -: OPW];
  wire           f_mode = imem_data[AW];
  wire [OPW-1:0] x_op   = ir[IW-1 -: OPW];
  wire           x_mode = ir[AW];
  wire [AW-1:0]  x_arg  = ir[AW-1:0];

  wire f_needs_mem = f_mode && (f_op == OP_ADD || f_op == OP_LOAD || f_op == OP_JUMP);
  wire in_exec     = (ph == PH_EXEC);
  wire stk_full    = (sp == SPW'(STACK_DEPTH));
  wire stk_empty   = (sp == '0);
  wire [SIW-1:0] top_idx = SIW'(sp - SPW'(1));
  wire [SIW-1:0] wr_idx  = SIW'(sp);
  wire [AW-1:0]  top_val = stk[top_idx];

  wire [DW-1:0] opnd     = x_mode ? dmem_rdata : DW'(x_arg);
  wire [AW-1:0] jump_tgt = x_mode ? dmem_rdata[AW-1:0] : x_arg;

  wire take_irq = in_exec && irq && ie_q;
  wire do_push  = (ph == PH_INTR) && !stk_full;
  wire do_pop   = in_exec && (x_op == OP_RET) && !stk_empty;
  wire bad_push = (ph == PH_INTR) && stk_full;
  wire bad_pop  = in_exec && (x_op == OP_RET) && stk_empty;

  always_comb begin
    pc_d = pc_q;
    case (ph)
      PH_FETCH: pc_d = pc_q + AW'(1);
      PH_EXEC: begin
        if (x_op == OP_JUMP) pc_d = jump_tgt;
        else if (do_pop)     pc_d = top_val;
      end
      PH_INTR: if (!stk_full) pc_d = ISR_ADDR;
      default: pc_d = pc_q;
    endcase
  end

  always_comb begin
    case (ph)
      PH_FETCH: ph_d = f_needs_mem ? PH_OPND : PH_EXEC;
      PH_OPND:  ph_d = PH_EXEC;
      PH_EXEC:  ph_d = take_irq ? PH_INTR : PH_FETCH;
      default:  ph_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= PH_FETCH;
      pc_q  <= '0;
      acc_q <= '0;
      ir    <= '0;
      ie_q  <= 1'b1;
      err_q <= 1'b0;
      sp    <= '0;
    end else begin
      ph   <= ph_d;
      pc_q <= pc_d;
      if (ph == PH_FETCH) ir <= imem_data;
      if (in_exec && x_op == OP_ADD)  acc_q <= acc_q + opnd;
      if (in_exec && x_op == OP_LOAD) acc_q <= opnd;
      if (do_push)     sp <= sp + SPW'(1);
      else if (do_pop) sp <= sp - SPW'(1);
      if (bad_push || bad_pop) err_q <= 1'b1;
      if (take_irq) ie_q <= 1'b0;
      else if (in_exec && (x_op == OP_RET || x_op == OP_ENI)) ie_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) stk[wr_idx] <= pc_q;
  end

  assign imem_addr = rst_n ? pc_d : '0;
  assign dmem_addr = x_arg;
  assign dmem_rd   = (ph == PH_OPND);
  assign phase     = ph;
  assign pc        = pc_q;
  assign acc       = acc_q;
  assign irq_en    = ie_q;
  assign stack_err = err_q;

  assert_opnd_to_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ph == PH_OPND |=> ph == PH_EXEC);
  assert_intr_to_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ph == PH_INTR |=> ph == PH_FETCH);
  assert_imm_skips_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_FETCH && !f_mode) |=> (ph == PH_EXEC && !dmem_rd));
  assert_read_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_FETCH && f_needs_mem) |=> (dmem_rd && dmem_addr == $past(imem_data[AW-1:0])));
  assert_fetch_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ph == PH_FETCH |=> pc_q == AW'($past(pc_q) + AW'(1)));
  assert_irq_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && irq && irq_en) |=> (ph == PH_INTR && !irq_en));
  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && !irq_en) |=> ph == PH_FETCH);
  assert_isr_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_INTR && !stk_full) |=> pc_q == ISR_ADDR);
  assert_pop_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && x_op == OP_RET && !stk_empty) |=> pc_q == $past(top_val));
  assert_full_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_INTR && stk_full) |=> (stack_err && pc_q == $past(pc_q)));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |=> stack_err);
endmodule

// File: tb/cycle_sequencer_tb_top.sv
module cycle_sequencer_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, irq;
  logic [10:0] imem_addr, dmem_addr, pc;
  logic [15:0] imem_q, dmem_q, acc;
  logic        dmem_rd, irq_en, stack_err;
  logic [1:0]  phase;

  logic [15:0] imem [2048];
  logic [15:0] dmem [2048];

  always @(posedge clk) begin
    imem_q <= imem[imem_addr];
    dmem_q <= dmem[dmem_addr];
  end

  cycle_sequencer dut_i (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_data(imem_q),
    .dmem_addr(dmem_addr), .dmem_rd(dmem_rd), .dmem_rdata(dmem_q),
    .irq(irq), .phase(phase), .pc(pc), .acc(acc),
    .irq_en(irq_en), .stack_err(stack_err)
  );

  typedef struct packed {
    logic [10:0] pc;
    logic [15:0] acc;
    logic        err;
    logic        ie;
    logic [15:0] tag;
  } item_t;

  item_t exp_q[$];
  int n_run = 0;
  int n_fail = 0;

  task automatic expect_fetch(input logic [10:0] p, input logic [15:0] a,
                              input logic e, input logic i, input logic [15:0] t);
    item_t it;
    it.pc = p; it.acc = a; it.err = e; it.ie = i; it.tag = t;
    exp_q.push_back(it);
  endtask

  always @(negedge clk) begin
    item_t got;
    if (rst_n && phase == 2'b00 && exp_q.size() > 0) begin
      got = exp_q.pop_front();
      n_run++;
      if (pc !== got.pc || acc !== got.acc || stack_err !== got.err || irq_en !== got.ie) begin
        n_fail++;
        $display("FAIL %s: fetch state pc=%h acc=%h err=%b ie=%b, expected pc=%h acc=%h err=%b ie=%b",
                 got.tag, pc, acc, stack_err, irq_en, got.pc, got.acc, got.err, got.ie);
      end
    end
  end

  task automatic check(input logic [15:0] tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic begin_reset();
    @(posedge clk); #2;
    rst_n = 1'b0;
    for (int k = 0; k < 2048; k++) begin
      imem[k] = 16'h0000;
      dmem[k] = 16'h0000;
    end
  endtask

  task automatic release_reset();
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() > 0 && guard < 2000) begin
      @(posedge clk);
      guard++;
    end
    if (exp_q.size() > 0) begin
      n_run++; n_fail++;
      $display("FAIL R2: scoreboard left=%0d expected=0", exp_q.size());
      exp_q.delete();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R2: watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    irq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "phase in reset", 32'(phase), 32'h0);
    check("R1", "pc in reset", 32'(pc), 32'h0);
    check("R1", "acc in reset", 32'(acc), 32'h0);
    check("R1", "irq_en in reset", 32'(irq_en), 32'h1);
    check("R1", "stack_err in reset", 32'(stack_err), 32'h0);

    // Program A: value and address modes, jumps
    begin_reset();
    irq = 1'b0;
    imem[0] = 16'h2005; imem[1] = 16'h17FF; imem[2] = 16'h1900;
    imem[3] = 16'h2901; imem[4] = 16'h1001; imem[5] = 16'h3020;
    imem[11'h21] = 16'h3902; imem[11'h41] = 16'h3041;
    dmem[11'h100] = 16'h1234; dmem[11'h101] = 16'hFFFF; dmem[11'h102] = 16'h0040;
    expect_fetch(11'h000, 16'h0000, 1'b0, 1'b1, "R1");
    expect_fetch(11'h001, 16'h0005, 1'b0, 1'b1, "R3");
    expect_fetch(11'h002, 16'h0804, 1'b0, 1'b1, "R3");
    expect_fetch(11'h003, 16'h1A38, 1'b0, 1'b1, "R4");
    expect_fetch(11'h004, 16'hFFFF, 1'b0, 1'b1, "R4");
    expect_fetch(11'h005, 16'h0000, 1'b0, 1'b1, "R3");
    expect_fetch(11'h020, 16'h0000, 1'b0, 1'b1, "R5");
    expect_fetch(11'h021, 16'h0000, 1'b0, 1'b1, "R5");
    expect_fetch(11'h040, 16'h0000, 1'b0, 1'b1, "R5");
    expect_fetch(11'h041, 16'h0000, 1'b0, 1'b1, "R5");
    release_reset();
    @(negedge clk); check("R1", "phase first cycle", 32'(phase), 32'h0);
    @(negedge clk); check("R2", "phase exec value-mode", 32'(phase), 32'h2);
    check("R3", "no data read in value mode", 32'(dmem_rd), 32'h0);
    @(negedge clk); check("R2", "phase fetch", 32'(phase), 32'h0);
    @(negedge clk); check("R3", "fetch skips operand phase", 32'(phase), 32'h2);
    @(negedge clk); check("R2", "phase fetch mem add", 32'(phase), 32'h0);
    @(negedge clk); check("R2", "phase operand read", 32'(phase), 32'h1);
    check("R4", "read strobe", 32'(dmem_rd), 32'h1);
    check("R4", "read address", 32'(dmem_addr), 32'h100);
    @(negedge clk); check("R2", "phase exec after read", 32'(phase), 32'h2);
    drain();

    // Program B: one interrupt, service routine, return
    begin_reset();
    irq = 1'b1;
    imem[0] = 16'h2001; imem[1] = 16'h1002; imem[2] = 16'h1004; imem[3] = 16'h3003;
    imem[11'h7F0] = 16'h1010; imem[11'h7F1] = 16'h4000;
    expect_fetch(11'h000, 16'h0000, 1'b0, 1'b1, "R6");
    expect_fetch(11'h7F0, 16'h0001, 1'b0, 1'b0, "R7");
    expect_fetch(11'h7F1, 16'h0011, 1'b0, 1'b0, "R6");
    expect_fetch(11'h001, 16'h0011, 1'b0, 1'b1, "R8");
    expect_fetch(11'h002, 16'h0013, 1'b0, 1'b1, "R8");
    expect_fetch(11'h003, 16'h0017, 1'b0, 1'b1, "R5");
    expect_fetch(11'h003, 16'h0017, 1'b0, 1'b1, "R5");
    release_reset();
    for (int g = 0; g < 50 && phase != 2'b11; g++) @(negedge clk);
    check("R7", "pc saved in interrupt phase", 32'(pc), 32'h001);
    check("R6", "interrupt phase code", 32'(phase), 32'h3);
    @(posedge clk); #2 irq = 1'b0;
    drain();

    // Program C: return with empty stack
    begin_reset();
    irq = 1'b0;
    imem[0] = 16'h4000; imem[2] = 16'h3002;
    expect_fetch(11'h000, 16'h0000, 1'b0, 1'b1, "R9");
    expect_fetch(11'h001, 16'h0000, 1'b1, 1'b1, "R9");
    expect_fetch(11'h002, 16'h0000, 1'b1, 1'b1, "R9");
    expect_fetch(11'h002, 16'h0000, 1'b1, 1'b1, "R9");
    release_reset();
    drain();

    // Program D: nested entries fill the stack, overflow, unwind
    begin_reset();
    irq = 1'b1;
    imem[1] = 16'h3001;
    imem[11'h7F0] = 16'h5000; imem[11'h7F1] = 16'h0000; imem[11'h7F2] = 16'h4000;
    expect_fetch(11'h000, 16'h0000, 1'b0, 1'b1, "R6");
    for (int n = 0; n < 4; n++) begin
      expect_fetch(11'h7F0, 16'h0000, 1'b0, 1'b0, "R7");
      expect_fetch(11'h7F1, 16'h0000, 1'b0, 1'b1, "R8");
    end
    expect_fetch(11'h7F2, 16'h0000, 1'b1, 1'b0, "R9");
    expect_fetch(11'h7F2, 16'h0000, 1'b1, 1'b1, "R8");
    expect_fetch(11'h7F2, 16'h0000, 1'b1, 1'b1, "R8");
    expect_fetch(11'h7F2, 16'h0000, 1'b1, 1'b1, "R8");
    expect_fetch(11'h001, 16'h0000, 1'b1, 1'b1, "R8");
    expect_fetch(11'h001, 16'h0000, 1'b1, 1'b1, "R9");
    release_reset();
    for (int g = 0; g < 200 && !stack_err; g++) @(negedge clk);
    check("R9", "overflow flag raised", 32'(stack_err), 32'h1);
    @(posedge clk); #2 irq = 1'b0;
    drain();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule